// File: doc/BRIEF.md
# Interleaved Burst Error Corrector

This block guards a block of 512 chunks, each 64 bits wide (4096 bytes), with ten 64-bit check words (80 bytes). Chunks arrive one per accepted beat with their index and with markers for the first and last beat. Every accepted chunk is folded into ten running check words. Word 9 takes every chunk. Word k, for k from 0 to 8, takes only the chunks whose index has bit k set. Every chunk is also written into an on-chip buffer at its index.

Used as an encoder, the block streams a clean block, and the ten computed check words are then read back one at a time through a selector. Used as a decoder, the received check words are first loaded through a load port, and then the received block is streamed. After the last beat, the block forms the syndrome, which is the received check words XORed with the recomputed ones.

The 64 bit lanes are independent of one another. In each lane where syndrome word 9 is set, syndrome words 8 down to 0 spell the index of the chunk whose bit in that lane is wrong. Any contiguous burst of up to 64 flipped bits hits each lane at most once, so one such burst is repaired. The repaired block is then streamed out in index order.

Top module: `ibc_corrector`

## Requirements
- R1: After a block, selecting `enc_sel = k` for k in 0..8 shows, on the next cycle, the XOR of every chunk whose 9-bit index has bit k set. `enc_sel = 9` shows the XOR of all 512 chunks.
- R2: A beat carrying `in_start` discards all earlier accumulation, so the check words restart from zero with that beat's chunk.
- R3: For each lane b with bit b of syndrome word 9 set, bit b is inverted in the output chunk whose index has bit k equal to bit b of syndrome word k (k = 0..8). Any single contiguous burst of 1 to 64 bits anywhere in the block, including across a chunk boundary, is fully repaired.
- R4: A lane with syndrome word 9 clear but any of syndrome words 0..8 set is left unmodified, and `uncorrectable` is 1 for that block. Otherwise `uncorrectable` is 0.
- R5: `err_count` gives the number of lanes that were repaired. It is set before the first output chunk and holds steady through the readout.
- R6: Beginning a few cycles after the `in_end` beat, `out_valid` presents chunks 0 to 511 on consecutive cycles, in ascending `out_idx` order.
- R7: `done` is high for exactly the one cycle that carries chunk 511.
- R8: Inputs on the chunk stream are ignored from the cycle after the `in_end` beat until the readout has issued its last buffer read.
- R9: After reset, `out_valid`, `done`, `err_count`, `uncorrectable` and `enc_word` are all zero.
- R10: A pulse on `ck_load` with `ck_sel = k` (k in 0..9) stores `ck_data` as received check word k. A selector value above 9 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Chunk beat valid |
| in_start | input | 1 | First beat of a block |
| in_end | input | 1 | Last beat of a block |
| in_idx | input | 9 | Chunk index of the beat |
| in_data | input | 64 | Chunk data |
| ck_load | input | 1 | Store one received check word |
| ck_sel | input | 4 | Which received check word to store |
| ck_data | input | 64 | Received check word value |
| enc_sel | input | 4 | Which computed check word to show |
| enc_word | output | 64 | Computed check word, registered |
| out_valid | output | 1 | Output chunk valid |
| out_idx | output | 9 | Output chunk index |
| out_data | output | 64 | Repaired chunk |
| done | output | 1 | Last output chunk of the block |
| err_count | output | 7 | Number of lanes repaired |
| uncorrectable | output | 1 | Inconsistent syndrome seen in some lane |

## Verification
The assertions assume that each block is preceded by a full set of ten received check words. They also assume that every index from 0 to 511 is streamed exactly once between a start beat and an end beat, so that each readout covers a full, freshly written buffer. The stimulus always loads all ten words before streaming and sends indices in ascending order with the markers on the first and last beats. It places junk on the stream only while the block is busy, which is the interval that requirement R8 says is ignored.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYN  = 2'd1,
    ST_READ = 2'd2
  } ibc_state_e;
endpackage

// File: rtl/ibc_accum.sv
module ibc_accum #(
  parameter int W  = 64,
  parameter int IW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  input  logic [IW-1:0]        idx,
  input  logic [W-1:0]         data,
  output logic [IW:0][W-1:0]   acc
);
  logic [IW:0] take;

  for (genvar k = 0; k <= IW; k++) begin : g_word
    if (k < IW) begin : g_pos
      assign take[k] = idx[k];
    end else begin : g_all
      assign take[k] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc[k] <= '0;
      end else if (en) begin
        acc[k] <= (start ? '0 : acc[k]) ^ (take[k] ? data : '0);
      end
    end
  end
endmodule

// File: rtl/ibc_locator.sv
module ibc_locator #(
  parameter int W  = 64,
  parameter int IW = 9
) (
  input  logic [IW:0][W-1:0]   acc,
  input  logic [IW:0][W-1:0]   rcv,
  output logic [W-1:0]         fix_en,
  output logic [W-1:0][IW-1:0] fix_idx,
  output logic [W-1:0]         bad
);
  logic [IW:0][W-1:0] syn;

  assign syn = acc ^ rcv;

  for (genvar b = 0; b < W; b++) begin : g_lane
    for (genvar k = 0; k < IW; k++) begin : g_bit
      assign fix_idx[b][k] = syn[k][b];
    end
    assign fix_en[b] = syn[IW][b];
    assign bad[b]    = !syn[IW][b] && (|fix_idx[b]);
  end
endmodule

// File: rtl/ibc_buffer.sv
module ibc_buffer #(
  parameter int W     = 64,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ibc_corrector.sv
module ibc_corrector
  import ibc_pkg::*;
#(
  parameter int W  = 64,
  parameter int IW = 9,
  localparam int NCHUNK = 1 << IW,
  localparam int SW     = $clog2(IW + 2),
  localparam int ECW    = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_end,
  input  logic [IW-1:0] in_idx,
  input  logic [W-1:0]  in_data,
  input  logic          ck_load,
  input  logic [SW-1:0] ck_sel,
  input  logic [W-1:0]  ck_data,
  input  logic [SW-1:0] enc_sel,
  output logic [W-1:0]  enc_word,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [W-1:0]  out_data,
  output logic          done,
  output logic [ECW-1:0] err_count,
  output logic          uncorrectable
);
  localparam logic [IW-1:0] LAST = IW'(NCHUNK - 1);

  ibc_state_e state;
  logic       accept;

  logic [IW:0][W-1:0]   acc;
  logic [IW:0][W-1:0]   rcv;
  logic [W-1:0]         fix_en;
  logic [W-1:0][IW-1:0] fix_idx;
  logic [W-1:0]         bad;

  logic [W-1:0]         fix_en_q;
  logic [W-1:0][IW-1:0] fix_idx_q;

  logic [IW-1:0] rd_ptr;
  logic          rd_v;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  ram_q;
  logic [W-1:0]  flip;

  assign accept = in_valid && (state == ST_IDLE);

  ibc_accum #(.W(W), .IW(IW)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .en    (accept),
    .start (in_start),
    .idx   (in_idx),
    .data  (in_data),
    .acc   (acc)
  );

  ibc_buffer #(.W(W), .DEPTH(NCHUNK)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (in_idx),
    .wdata (in_data),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  ibc_locator #(.W(W), .IW(IW)) u_loc (
    .acc     (acc),
    .rcv     (rcv),
    .fix_en  (fix_en),
    .fix_idx (fix_idx),
    .bad     (bad)
  );

  for (genvar k = 0; k <= IW; k++) begin : g_rcv
    always_ff @(posedge clk) begin
      if (rst) begin
        rcv[k] <= '0;
      end else if (ck_load && ck_sel == SW'(k)) begin
        rcv[k] <= ck_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_word <= '0;
    end else if (enc_sel <= SW'(IW)) begin
      enc_word <= acc[enc_sel];
    end else begin
      enc_word <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      rd_ptr        <= '0;
      rd_v          <= 1'b0;
      rd_idx        <= '0;
      fix_en_q      <= '0;
      fix_idx_q     <= '0;
      err_count     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      rd_v <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept && in_end) state <= ST_SYN;
        end
        ST_SYN: begin
          fix_en_q      <= fix_en;
          fix_idx_q     <= fix_idx;
          err_count     <= ECW'($countones(fix_en));
          uncorrectable <= |bad;
          rd_ptr        <= '0;
          state         <= ST_READ;
        end
        ST_READ: begin
          rd_v   <= 1'b1;
          rd_idx <= rd_ptr;
          rd_ptr <= rd_ptr + 1'b1;
          if (rd_ptr == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_flip
    assign flip[b] = fix_en_q[b] && (fix_idx_q[b] == rd_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= rd_v;
      out_idx   <= rd_idx;
      out_data  <= ram_q ^ flip;
      done      <= rd_v && (rd_idx == LAST);
    end
  end
endmodule

// File: rtl/ibc_checker.sv
module ibc_checker #(
  parameter int W  = 64,
  parameter int IW = 9,
  localparam int ECW = $clog2(W + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic [IW-1:0]  out_idx,
  input logic [W-1:0]   out_data,
  input logic           done,
  input logic [ECW-1:0] err_count,
  input logic [W-1:0]   ram_q
);
  localparam logic [IW-1:0] LAST = IW'((1 << IW) - 1);

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_idx == LAST));

  // R6
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_idx == IW'($past(out_idx) + 1'b1)));

  // R6
  first_idx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_idx == '0));

  // R5
  err_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(err_count));

  // R5
  err_range_chk: assert property (@(posedge clk) disable iff (rst)
    err_count <= ECW'(W));

  // R3
  flip_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_data ^ $past(ram_q)) <= int'(err_count)));
endmodule

bind ibc_corrector ibc_checker #(.W(W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_data  (out_data),
  .done      (done),
  .err_count (err_count),
  .ram_q     (ram_q)
);

// File: tb/tb_ibc_corrector.sv
`timescale 1ns/1ps
module tb_ibc_corrector;
  localparam int W = 64;
  localparam int IW = 9;
  localparam int N = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          in_valid = 0, in_start = 0, in_end = 0;
  logic [IW-1:0] in_idx = '0;
  logic [W-1:0]  in_data = '0;
  logic          ck_load = 0;
  logic [3:0]    ck_sel = '0;
  logic [W-1:0]  ck_data = '0;
  logic [3:0]    enc_sel = '0;
  logic [W-1:0]  enc_word;
  logic          out_valid;
  logic [IW-1:0] out_idx;
  logic [W-1:0]  out_data;
  logic          done;
  logic [6:0]    err_count;
  logic          uncorrectable;

  ibc_corrector dut (.*);

  int checks = 0;
  int failures = 0;
  logic [W-1:0] clean [N];
  logic [W-1:0] sent  [N];
  logic [W-1:0] got   [N];
  logic [W-1:0] model [IW+1];
  int order_err, done_err, nout, err_seen, unc_seen, err_changed;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input int seed);
    for (int k = 0; k <= IW; k++) model[k] = '0;
    for (int i = 0; i < N; i++) begin
      clean[i] = (64'(i + 1) * 64'h9E3779B97F4A7C15) ^ {32'(seed) * 32'h01000193, ~32'(seed)};
      sent[i] = clean[i];
      model[IW] ^= clean[i];
      for (int k = 0; k < IW; k++) if (i[k]) model[k] ^= clean[i];
    end
  endtask

  task automatic burst(input int p, input int len);
    for (int i = 0; i < len; i++) sent[(p + i) / W][(p + i) % W] ^= 1'b1;
  endtask

  task automatic load_checks(input int bad_k, input logic [W-1:0] bad_m);
    for (int k = 0; k <= IW; k++) begin
      @(negedge clk);
      ck_load = 1; ck_sel = 4'(k);
      ck_data = model[k] ^ ((k == bad_k) ? bad_m : '0);
    end
    @(negedge clk);
    ck_load = 0;
  endtask

  task automatic send_and_collect(input bit junk);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_end = (i == N - 1);
      in_idx = IW'(i); in_data = sent[i];
    end
    order_err = 0; done_err = 0; nout = 0; err_changed = 0;
    for (int t = 0; t < 3000 && nout < N; t++) begin
      @(negedge clk);
      if (junk && nout == 0) begin
        in_valid = 1; in_start = t[0]; in_end = t[1];
        in_idx = IW'(t * 37); in_data = {2{32'(t) * 32'h2545F491}};
      end else begin
        in_valid = 0; in_start = 0; in_end = 0;
      end
      if (out_valid) begin
        if (out_idx != IW'(nout)) order_err++;
        if (done != (nout == N - 1)) done_err++;
        if (nout == 0) begin err_seen = err_count; unc_seen = uncorrectable; end
        else if (err_count != 7'(err_seen)) err_changed++;
        got[out_idx] = out_data;
        nout++;
      end else if (done) done_err++;
    end
    in_valid = 0; in_start = 0; in_end = 0;
  endtask

  task automatic verify(input string req, input logic [W-1:0] bad_lanes, input int exp_err, input bit exp_unc);
    int mis;
    int first;
    mis = 0; first = -1;
    for (int i = 0; i < N; i++) begin
      if (got[i] !== ((clean[i] & ~bad_lanes) | (sent[i] & bad_lanes))) begin
        mis++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(mis == 0, {req, " data"}, got[first], (clean[first] & ~bad_lanes) | (sent[first] & bad_lanes));
    // R6 order and count
    check(order_err == 0 && nout == N, {req, " R6 order"}, 64'(order_err), 64'(0));
    // R7 done pulse
    check(done_err == 0, {req, " R7 done"}, 64'(done_err), 64'(0));
    // R5 err_count
    check(err_seen == exp_err && err_changed == 0, {req, " R5 err_count"}, 64'(err_seen), 64'(exp_err));
    // R4 flag
    check(unc_seen == int'(exp_unc), {req, " R4 uncorrectable"}, 64'(unc_seen), 64'(exp_unc));
  endtask

  task automatic check_enc(input string req);
    for (int k = 0; k <= IW; k++) begin
      @(negedge clk);
      enc_sel = 4'(k);
      @(negedge clk);
      check(enc_word === model[k], req, enc_word, model[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!out_valid && !done && err_count == 0 && !uncorrectable && enc_word == 0,
          "R9 reset outputs", {out_valid, done, uncorrectable, err_count}, 64'(0));
    rst = 0;

    // R1 clean encode, R3 no change
    build(1);
    load_checks(-1, '0);
    send_and_collect(0);
    verify("R3 clean", '0, 0, 0);
    check_enc("R1 check words seed1");

    // R2 restart at start marker
    build(2);
    load_checks(-1, '0);
    send_and_collect(0);
    verify("R2 second block", '0, 0, 0);
    check_enc("R2 check words restart");

    // R3 single error chunk 185 lane 0
    build(3);
    load_checks(-1, '0);
    sent[185][0] ^= 1'b1;
    send_and_collect(0);
    verify("R3 single 185", '0, 1, 0);

    // R3 R8 burst 64 across boundary, junk while busy
    build(4);
    load_checks(-1, '0);
    burst(100 * W + 30, 64);
    send_and_collect(1);
    verify("R3 R8 burst64 boundary", '0, 64, 0);

    // R3 burst covering whole chunk 0
    build(5);
    load_checks(-1, '0);
    burst(0, 64);
    send_and_collect(0);
    verify("R3 burst chunk0", '0, 64, 0);

    // R3 burst at the very end of the block
    build(6);
    load_checks(-1, '0);
    burst(N * W - 17, 17);
    send_and_collect(1);
    verify("R3 burst tail", '0, 17, 0);

    // R4 received word 3 bit 5 corrupted, plus error in chunk 7 lane 9
    build(7);
    load_checks(3, 64'h20);
    sent[7][9] ^= 1'b1;
    send_and_collect(0);
    verify("R4 bad check word", 64'h20, 1, 1);

    // R4 two errors in one lane
    build(8);
    load_checks(-1, '0);
    sent[10][0] ^= 1'b1;
    sent[20][0] ^= 1'b1;
    send_and_collect(0);
    verify("R4 double lane0", 64'h1, 0, 1);

    // R10 out-of-range selector ignored
    build(9);
    load_checks(-1, '0);
    @(negedge clk);
    ck_load = 1; ck_sel = 4'd12; ck_data = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk);
    ck_sel = 4'd15;
    @(negedge clk);
    ck_load = 0;
    send_and_collect(0);
    verify("R10 sel ignored", '0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule